// File: doc/BRIEF.md
# Asynchronous External Bus Sequencer

This block runs an 8- or 16-bit asynchronous memory bus on behalf of an internal requester. Up to four device banks (ROM, SRAM, Flash or simple peripherals) each have their own address window and their own timing. A request carries an address, a direction, a byte or halfword size and an item count. The block picks the bank from the windows and then walks through one or more bus beats. In each beat it drives the address, asserts that bank's chip select and the read or write strobe at programmed offsets, and waits out a programmed count. When the bank asks for it, the block also waits for an external Ready line.

Read data returns with a one-cycle valid pulse per item. Write data is taken from a held input, and a take pulse tells the requester when to present the next item. A transfer ends with a one-cycle done pulse, which carries an error flag for an address that hits no bank or a Ready wait that times out. Only one transfer is in flight. Configuration is written through a plain register write port, with two words per bank.

Top module: `xbus_ctrl`

## Requirements
- R1: A bank is hit when it is enabled and `((req_addr[23:16] ^ base) & mask) == 0`. The window word is written with cfg_sel=0 and uses bit 0 enable, bit 1 16-bit width, bit 2 Ready enable, bit 3 Ready asynchronous, bit 4 timeout enable, bits 12:5 base and bits 20:13 mask. When windows overlap, the lowest bank index wins, and only `bus_cs_n[bank]` of that bank ever goes low.
- R2: A request that hits no enabled bank is accepted and produces done=1 with err=1 in the next cycle, with no chip select or strobe asserted.
- R3: The timing word is written with cfg_sel=1 and uses bits 7:0 single wait, 12:8 first-beat wait, 15:13 later-beat wait, 18:16 cs_on, 21:19 cs_off, 24:22 st_on and 27:25 st_off. Beat cycles are numbered from 0 at the cycle the address is driven. Data is sampled at the end of cycle E = cs_on + st_on + wait. For a single-item transfer (req_len=0) the wait is the single wait, so each beat lasts E+1 cycles when Ready is not involved.
- R4: In a transfer with req_len>0, the first beat uses the first-beat wait (0 to 31) and every later beat uses the later-beat wait (0 to 7).
- R5: Chip select is low in beat cycles [cs_on, cs_off). If cs_off <= cs_on or cs_off > E+1, the end is clamped to E+1.
- R6: The output enable (reads) or write enable (writes) is low in beat cycles [cs_on+st_on, cs_on+st_off). If st_off <= st_on or cs_on+st_off > E+1, the end is clamped to E+1. The two strobes are never low together.
- R7: With Ready enabled and synchronous, the beat holds at cycle E until bus_ready is high at a rising clock edge.
- R8: With Ready enabled and asynchronous, bus_ready passes through two flops first, so a rise is seen two cycles later.
- R9: With Ready disabled, bus_ready has no effect on any beat.
- R10: With Ready and timeout enabled, the 2048th cycle spent waiting at E without Ready ends the transfer with done=1 and err=1. With timeout disabled, the wait continues past 2048 cycles.
- R11: On an 8-bit bank a halfword item takes two beats, low byte first at the item address and then the high byte at address+1, and each beat advances the address by 1. On a 16-bit bank each item is one beat and the address advances by 2 for halfwords and by 1 for bytes. Bytes use lane 7:0.
- R12: req_ready is high only while no transfer is active. done pulses in the cycle after the final beat ends.
- R13: rd_valid pulses with rd_data one cycle after a read item's last beat ends, with zeros above a byte. wr_take is high in the final cycle of each write item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Bank written |
| cfg_sel | input | 1 | 0 window word, 1 timing word |
| cfg_wdata | input | 28 | Configuration data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, request accepted |
| req_addr | input | 24 | Byte address |
| req_wr | input | 1 | 1 write, 0 read |
| req_half | input | 1 | 1 halfword, 0 byte |
| req_len | input | 4 | Items minus one |
| req_wdata | input | 16 | Write data of current item |
| wr_take | output | 1 | Current write item consumed |
| rd_valid | output | 1 | Read item valid |
| rd_data | output | 16 | Read item data |
| done | output | 1 | Transfer finished |
| err | output | 1 | Finished with error |
| bus_addr | output | 24 | External address |
| bus_cs_n | output | 4 | Chip selects, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_dout | output | 16 | Write data to bus |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data from bus |
| bus_ready | input | 1 | Device Ready |

## Verification
The bench targets offset values that must be clamped. A design that skipped the clamp would drop chip select or the strobe before it was asserted, or let it outlast the beat. It also runs first and later burst beats, where a swapped wait count shifts every later strobe. Halfwords on 8-bit banks catch a swapped byte order or a missing address step. The Ready paths are exercised in both synchronous and asynchronous mode, which exposes a missing or extra synchronizer stage as a one- or two-cycle error in the end of the beat. The timeout is tested at exactly 2048 waiting cycles and again with the timeout disabled, where an off-by-one or an ignored disable shows up as a misplaced or spurious error.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int CFG_W = 28;

    // window word: mask, base, then five flag bits (LSB = enable)
    typedef struct packed {
        logic [7:0] mask;
        logic [7:0] base;
        logic       tmo_en;
        logic       rdy_async;
        logic       rdy_en;
        logic       wide;
        logic       en;
    } win_t;

    // timing word
    typedef struct packed {
        logic [2:0] st_off;
        logic [2:0] st_on;
        logic [2:0] cs_off;
        logic [2:0] cs_on;
        logic [2:0] sb_wait;
        logic [4:0] fb_wait;
        logic [7:0] nb_wait;
    } tim_t;

    localparam int WIN_W = $bits(win_t);

endpackage

// File: rtl/xbus_cfg.sv
module xbus_cfg
    import xbus_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(NBANK)-1:0] cfg_bank,
    input  logic                     cfg_sel,
    input  logic [CFG_W-1:0]         cfg_wdata,
    output win_t                     win [NBANK],
    output tim_t                     tim [NBANK]
);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        win_t win_d, win_q;
        tim_t tim_d, tim_q;

        always_comb begin
            win_d = win_q;
            tim_d = tim_q;
            if (cfg_we && cfg_bank == g) begin
                if (cfg_sel) tim_d = tim_t'(cfg_wdata);
                else         win_d = win_t'(cfg_wdata[WIN_W-1:0]);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_q <= '0;
                tim_q <= '0;
            end else begin
                win_q <= win_d;
                tim_q <= tim_d;
            end
        end

        assign win[g] = win_q;
        assign tim[g] = tim_q;
    end

endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
    import xbus_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic [7:0]               page,
    input  win_t                     win [NBANK],
    output logic                     hit,
    output logic [$clog2(NBANK)-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        // scan downwards so the lowest matching index is left last
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (win[i].en && (((page ^ win[i].base) & win[i].mask) == 8'h00)) begin
                hit = 1'b1;
                idx = i[$clog2(NBANK)-1:0];
            end
        end
    end

endmodule

// File: rtl/xbus_rdy.sv
module xbus_rdy #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_raw,
    input  logic async_sel,
    output logic rdy
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], rdy_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rdy = async_sel ? sync_q[STAGES-1] : rdy_raw;

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int AW    = 24,
    parameter int LEN_W = 4,
    parameter int TMO   = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(NBANK)-1:0] cfg_bank,
    input  logic                     cfg_sel,
    input  logic [CFG_W-1:0]         cfg_wdata,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [AW-1:0]            req_addr,
    input  logic                     req_wr,
    input  logic                     req_half,
    input  logic [LEN_W-1:0]         req_len,
    input  logic [15:0]              req_wdata,
    output logic                     wr_take,
    output logic                     rd_valid,
    output logic [15:0]              rd_data,
    output logic                     done,
    output logic                     err,
    output logic [AW-1:0]            bus_addr,
    output logic [NBANK-1:0]         bus_cs_n,
    output logic                     bus_oe_n,
    output logic                     bus_we_n,
    output logic [15:0]              bus_dout,
    output logic                     bus_dout_en,
    input  logic [15:0]              bus_din,
    input  logic                     bus_ready
);

    localparam int BW = $clog2(NBANK);
    localparam int CW = 10;
    localparam int TW = $clog2(TMO) + 1;

    typedef enum logic {S_IDLE, S_BEAT} st_e;

    typedef struct packed {
        st_e            st;
        logic [BW-1:0]  bank;
        logic [AW-1:0]  addr;
        logic           wr;
        logic           half;
        logic           burst;
        logic           first;
        logic [LEN_W-1:0] items;
        logic           sub;
        logic [CW-1:0]  cnt;
        logic [TW-1:0]  tmo;
        logic [7:0]     lo;
        logic           rvld;
        logic [15:0]    rdata;
        logic           done;
        logic           err;
    } ctl_t;

    ctl_t r_q, r_d;

    win_t win [NBANK];
    tim_t tim [NBANK];
    logic          dec_hit;
    logic [BW-1:0] dec_idx;
    logic          rdy_s;

    xbus_cfg #(.NBANK(NBANK)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_bank  (cfg_bank),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .win       (win),
        .tim       (tim)
    );

    xbus_decode #(.NBANK(NBANK)) i_dec (
        .page (req_addr[AW-1 -: 8]),
        .win  (win),
        .hit  (dec_hit),
        .idx  (dec_idx)
    );

    win_t w_cur;
    tim_t t_cur;
    assign w_cur = win[r_q.bank];
    assign t_cur = tim[r_q.bank];

    xbus_rdy #(.STAGES(2)) i_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdy_raw   (bus_ready),
        .async_sel (w_cur.rdy_async),
        .rdy       (rdy_s)
    );

    // beat timeline
    logic [CW-1:0] wait_sel, s_on, e_pt, e_nx, cs_hi, st_abs, st_hi;
    logic          act, cs_act, st_act, at_end, rdy_ok, tmo_hit, two_beat, last_sub;
    logic [AW-1:0] step;

    always_comb begin
        if (!r_q.burst)    wait_sel = CW'(t_cur.nb_wait);
        else if (r_q.first) wait_sel = CW'(t_cur.fb_wait);
        else               wait_sel = CW'(t_cur.sb_wait);
        s_on   = CW'(t_cur.cs_on) + CW'(t_cur.st_on);
        e_pt   = s_on + wait_sel;
        e_nx   = e_pt + CW'(1);
        cs_hi  = (t_cur.cs_off <= t_cur.cs_on || CW'(t_cur.cs_off) > e_nx) ? e_nx : CW'(t_cur.cs_off);
        st_abs = CW'(t_cur.cs_on) + CW'(t_cur.st_off);
        st_hi  = (t_cur.st_off <= t_cur.st_on || st_abs > e_nx) ? e_nx : st_abs;
        act      = (r_q.st == S_BEAT);
        cs_act   = act && r_q.cnt >= CW'(t_cur.cs_on) && r_q.cnt < cs_hi;
        st_act   = act && r_q.cnt >= s_on && r_q.cnt < st_hi;
        at_end   = act && r_q.cnt == e_pt;
        rdy_ok   = !w_cur.rdy_en || rdy_s;
        tmo_hit  = w_cur.rdy_en && w_cur.tmo_en && !rdy_s && r_q.tmo == TW'(TMO - 1);
        two_beat = r_q.half && !w_cur.wide;
        last_sub = !two_beat || r_q.sub;
        step     = (w_cur.wide && r_q.half) ? AW'(2) : AW'(1);
    end

    always_comb begin
        r_d       = r_q;
        r_d.rvld  = 1'b0;
        r_d.done  = 1'b0;
        r_d.err   = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    if (dec_hit) begin
                        r_d.st    = S_BEAT;
                        r_d.bank  = dec_idx;
                        r_d.addr  = req_addr;
                        r_d.wr    = req_wr;
                        r_d.half  = req_half;
                        r_d.burst = (req_len != '0);
                        r_d.first = 1'b1;
                        r_d.items = req_len;
                        r_d.sub   = 1'b0;
                        r_d.cnt   = '0;
                        r_d.tmo   = '0;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end
                end
            end
            default: begin
                if (!at_end) begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end else if (tmo_hit) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                end else if (rdy_ok) begin
                    if (!r_q.wr && two_beat && !r_q.sub) r_d.lo = bus_din[7:0];
                    if (!r_q.wr && last_sub) begin
                        r_d.rvld = 1'b1;
                        if (two_beat)    r_d.rdata = {bus_din[7:0], r_q.lo};
                        else if (r_q.half) r_d.rdata = bus_din;
                        else             r_d.rdata = {8'h00, bus_din[7:0]};
                    end
                    r_d.addr  = r_q.addr + step;
                    r_d.cnt   = '0;
                    r_d.tmo   = '0;
                    r_d.first = 1'b0;
                    if (!last_sub) begin
                        r_d.sub = 1'b1;
                    end else if (r_q.items == '0) begin
                        r_d.st   = S_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.items = r_q.items - LEN_W'(1);
                        r_d.sub   = 1'b0;
                    end
                end else if (w_cur.rdy_en && w_cur.tmo_en) begin
                    r_d.tmo = r_q.tmo + TW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_cs
        assign bus_cs_n[g] = !(cs_act && r_q.bank == g);
    end

    assign req_ready   = (r_q.st == S_IDLE);
    assign bus_addr    = r_q.addr;
    assign bus_oe_n    = !(st_act && !r_q.wr);
    assign bus_we_n    = !(st_act && r_q.wr);
    assign bus_dout_en = act && r_q.wr;
    assign bus_dout    = two_beat ? {8'h00, (r_q.sub ? req_wdata[15:8] : req_wdata[7:0])}
                       : (r_q.half ? req_wdata : {8'h00, req_wdata[7:0]});
    assign wr_take     = at_end && !tmo_hit && rdy_ok && last_sub && r_q.wr;
    assign rd_valid    = r_q.rvld;
    assign rd_data     = r_q.rdata;
    assign done        = r_q.done;
    assign err         = r_q.err;

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] bus_cs_n,
    input logic             bus_oe_n,
    input logic             bus_we_n,
    input logic             bus_dout_en,
    input logic             req_ready,
    input logic             done,
    input logic             err
);

    AST_ONE_CHIP_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n)); // R1

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&bus_cs_n && bus_oe_n && bus_we_n)); // R2

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n)); // R6

    AST_WRITE_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> bus_dout_en); // R6

    AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R10

    AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R12

endmodule

bind xbus_ctrl xbus_ctrl_chk #(.NBANK(NBANK)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_cs_n    (bus_cs_n),
    .bus_oe_n    (bus_oe_n),
    .bus_we_n    (bus_we_n),
    .bus_dout_en (bus_dout_en),
    .req_ready   (req_ready),
    .done        (done),
    .err         (err)
);

// File: tb/test_xbus_ctrl.sv
`timescale 1ns/1ps
module test_xbus_ctrl;

    localparam int TMO = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic        cfg_sel = 1'b0;
    logic [27:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic        req_half = 1'b0;
    logic [3:0]  req_len = '0;
    logic [15:0] req_wdata = '0;
    logic        wr_take, rd_valid, done, err;
    logic [15:0] rd_data;
    logic [23:0] bus_addr;
    logic [3:0]  bus_cs_n;
    logic        bus_oe_n, bus_we_n, bus_dout_en;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_ready = 1'b0;

    int vec_n = 0;
    int bad_n = 0;
    logic [27:0] winw [4];
    logic [27:0] timw [4];
    logic rh1 = 1'b0, rh2 = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        rh1 <= bus_ready;
        rh2 <= rh1;
    end

    xbus_ctrl i_xbus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wr(req_wr), .req_half(req_half), .req_len(req_len), .req_wdata(req_wdata),
        .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_ready(bus_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_n++;
        if (!ok) begin
            bad_n++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input logic [23:0] a);
        return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C};
    endfunction

    function automatic int bank_of(input logic [23:0] a);
        for (int i = 0; i < 4; i++) begin
            if (winw[i][0] && (((a[23:16] ^ winw[i][12:5]) & winw[i][20:13]) == 8'h00)) return i;
        end
        return -1;
    endfunction

    function automatic logic [27:0] mkwin(input bit en, input bit wide, input bit ren, input bit ras,
                                          input bit ten, input logic [7:0] base, input logic [7:0] mask);
        return {7'h0, mask, base, ten, ras, ren, wide, en};
    endfunction

    function automatic logic [27:0] mktim(input int nb, input int fb, input int sb, input int cson,
                                          input int csoff, input int ston, input int stoff);
        return {stoff[2:0], ston[2:0], csoff[2:0], cson[2:0], sb[2:0], fb[4:0], nb[7:0]};
    endfunction

    task automatic cfg(input int b, input bit sel, input logic [27:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = b[1:0]; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (sel) timw[b] = d; else winw[b] = d;
    endtask

    // rdly: cycles after E at which Ready rises (-1: never)
    task automatic xfer(input logic [23:0] a, input bit wr, input bit half, input int len, input int rdly);
        int b;
        logic [15:0] wd [16];
        logic [23:0] cur;
        bit wide, ren, ras, ten, burst, first, two, fail_end, pend;
        int nb, fb, sb, cson, csoff, ston, stoff;
        logic [15:0] rexp;
        string dtag;
        b = bank_of(a);
        for (int i = 0; i < 16; i++) wd[i] = 16'($urandom);
        @(negedge clk);
        chk(req_ready == 1'b1, "R12", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = a; req_wr = wr; req_half = half;
        req_len = len[3:0]; req_wdata = wd[0];
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (b < 0) begin
            @(negedge clk);
            chk(done && err, "R2", {30'd0, done, err}, 32'd3);
            chk(&bus_cs_n && bus_oe_n && bus_we_n, "R2", 32'(bus_cs_n), 32'hF);
            return;
        end
        wide = winw[b][1]; ren = winw[b][2]; ras = winw[b][3]; ten = winw[b][4];
        nb = int'(timw[b][7:0]); fb = int'(timw[b][12:8]); sb = int'(timw[b][15:13]);
        cson = int'(timw[b][18:16]); csoff = int'(timw[b][21:19]);
        ston = int'(timw[b][24:22]); stoff = int'(timw[b][27:25]);
        two = half && !wide;
        burst = (len != 0);
        first = 1'b1;
        cur = a;
        fail_end = 1'b0;
        pend = 1'b0;
        rexp = '0;
        if (ten && ren && rdly < 0) dtag = "R10";
        else if (ren && ras) dtag = "R8";
        else if (ren) dtag = "R7";
        else if (rdly >= 0) dtag = "R9";
        else if (burst) dtag = "R4";
        else dtag = "R3";
        for (int it = 0; it <= len && !fail_end; it++) begin
            for (int s = 0; s <= (two ? 1 : 0) && !fail_end; s++) begin
                int wt, son, e, cshi, sthi, k, c;
                bit endnow, errnow, lastsub, vis;
                logic [3:0] ecs;
                wt = !burst ? nb : (first ? fb : sb);
                son = cson + ston;
                e = son + wt;
                cshi = (csoff <= cson || csoff > e + 1) ? e + 1 : csoff;
                sthi = (stoff <= ston || cson + stoff > e + 1) ? e + 1 : cson + stoff;
                lastsub = !two || (s == 1);
                k = 0;
                endnow = 1'b0;
                while (!endnow) begin
                    bus_din = pat(cur);
                    bus_ready = (rdly >= 0) && (k >= e + rdly);
                    @(negedge clk);
                    c = (k < e) ? k : e;
                    ecs = 4'hF;
                    if (c >= cson && c < cshi) ecs[b] = 1'b0;
                    chk(bus_cs_n == ecs, "R1,R5", 32'(bus_cs_n), 32'(ecs));
                    chk(bus_oe_n == !(!wr && c >= son && c < sthi), "R6", 32'(bus_oe_n), 32'(!(!wr && c >= son && c < sthi)));
                    chk(bus_we_n == !(wr && c >= son && c < sthi), "R6", 32'(bus_we_n), 32'(!(wr && c >= son && c < sthi)));
                    chk(bus_addr == cur, "R11", 32'(bus_addr), 32'(cur));
                    chk(req_ready == 1'b0, "R12", 32'(req_ready), 32'd0);
                    if (!bus_we_n) begin
                        logic [15:0] ed;
                        ed = two ? {8'h00, (s == 1 ? wd[it][15:8] : wd[it][7:0])}
                                 : (half ? wd[it] : {8'h00, wd[it][7:0]});
                        chk(bus_dout == ed, "R11", 32'(bus_dout), 32'(ed));
                    end
                    if (pend) begin
                        chk(rd_valid && rd_data == rexp, "R13", {15'd0, rd_valid, rd_data}, {16'd1, rexp});
                        pend = 1'b0;
                    end
                    errnow = 1'b0;
                    if (k >= e) begin
                        vis = ras ? rh2 : bus_ready;
                        if (!ren || vis) endnow = 1'b1;
                        else if (ten && (k - e + 1) == TMO) begin
                            endnow = 1'b1;
                            errnow = 1'b1;
                        end
                    end
                    chk(wr_take == (wr && endnow && !errnow && lastsub), "R13", 32'(wr_take),
                        32'(wr && endnow && !errnow && lastsub));
                    if (endnow && !errnow && !wr) begin
                        if (two && s == 0) rexp[7:0] = pat(cur)[7:0];
                        else if (two) begin rexp[15:8] = pat(cur)[7:0]; pend = 1'b1; end
                        else begin rexp = half ? pat(cur) : {8'h00, pat(cur)[7:0]}; pend = 1'b1; end
                    end
                    @(posedge clk); #1;
                    if (endnow) begin
                        if (errnow) fail_end = 1'b1;
                        cur = cur + ((wide && half) ? 24'd2 : 24'd1);
                        first = 1'b0;
                        if (lastsub && it < 15) req_wdata = wd[it + 1];
                    end else begin
                        k++;
                    end
                end
            end
        end
        bus_ready = 1'b0;
        @(negedge clk);
        chk(done == 1'b1 && err == fail_end, dtag, {30'd0, done, err}, {30'd0, 1'b1, fail_end});
        if (pend) chk(rd_valid && rd_data == rexp, "R13", {15'd0, rd_valid, rd_data}, {16'd1, rexp});
        if (fail_end) chk(rd_valid == 1'b0, "R10", 32'(rd_valid), 32'd0);
        chk(req_ready == 1'b1, "R12", 32'(req_ready), 32'd1);
    endtask

    initial begin
        #(200000 * 20);
        bad_n++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin winw[i] = '0; timw[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(&bus_cs_n && bus_oe_n && bus_we_n, "R12", {bus_oe_n, bus_we_n, bus_cs_n}, 32'h3F);
        chk(req_ready && !done && !rd_valid, "R12", {req_ready, done, rd_valid}, 32'h4);

        // bank0: 16-bit, sync Ready; bank1: 8-bit, no Ready; bank2: 16-bit, async Ready
        cfg(0, 0, mkwin(1, 1, 1, 0, 1, 8'h00, 8'hC0));
        cfg(0, 1, mktim(2, 4, 1, 1, 0, 1, 0));
        cfg(1, 0, mkwin(1, 0, 0, 0, 0, 8'h40, 8'hC0));
        cfg(1, 1, mktim(2, 3, 1, 0, 0, 0, 0));
        cfg(2, 0, mkwin(1, 1, 1, 1, 1, 8'h80, 8'hE0));
        cfg(2, 1, mktim(3, 5, 2, 1, 6, 1, 3));

        xfer(24'hE01234, 0, 1, 0, -1);           // R2 miss
        xfer(24'hA00010, 1, 0, 0, -1);           // R2 disabled bank
        xfer(24'h401000, 0, 1, 0, -1);           // R3 R11 8-bit half read
        xfer(24'h401101, 1, 1, 2, -1);           // R4 R11 burst write
        xfer(24'h410020, 0, 0, 0, 2);            // R9 Ready ignored
        xfer(24'h000100, 0, 1, 0, 3);            // R7 sync stretch
        xfer(24'h000200, 1, 1, 3, 0);            // R4 R7 burst
        xfer(24'h800300, 0, 1, 0, 1);            // R8 async stretch
        xfer(24'h800400, 1, 0, 1, 0);            // R8 burst

        // R5 R6 clamping: negation at or before assertion
        cfg(1, 1, mktim(1, 2, 0, 3, 2, 2, 1));
        xfer(24'h420000, 0, 0, 0, -1);
        cfg(1, 1, mktim(0, 0, 0, 2, 7, 1, 7));
        xfer(24'h420010, 1, 1, 1, -1);
        // R3 longest single wait
        cfg(1, 1, mktim(255, 0, 0, 0, 0, 0, 0));
        xfer(24'h430000, 0, 0, 0, -1);

        // R1 overlap: bank3 same window as bank2, lower index must win
        cfg(3, 0, mkwin(1, 0, 0, 0, 0, 8'h80, 8'hE0));
        cfg(3, 1, mktim(0, 0, 0, 0, 0, 0, 0));
        xfer(24'h810000, 0, 1, 0, 0);
        cfg(3, 0, mkwin(1, 0, 0, 0, 0, 8'hA0, 8'hE0));
        xfer(24'hA10000, 0, 0, 0, -1);

        // R10 timeout, then disabled timeout waits past the limit
        xfer(24'h000500, 0, 1, 0, -1);
        cfg(0, 0, mkwin(1, 1, 1, 0, 0, 8'h00, 8'hC0));
        xfer(24'h000600, 0, 1, 0, TMO + 40);
        cfg(0, 0, mkwin(1, 1, 1, 0, 1, 8'h00, 8'hC0));

        for (int n = 0; n < 60; n++) begin
            logic [23:0] a;
            int rd;
            if (n % 10 == 0) begin
                for (int b = 0; b < 4; b++) begin
                    cfg(b, 1, mktim($urandom % 12, $urandom % 32, $urandom % 8, $urandom % 8,
                                    $urandom % 8, $urandom % 8, $urandom % 8));
                end
            end
            a = 24'($urandom);
            rd = int'($urandom % 5) - 1;
            xfer(a, 1'($urandom), 1'($urandom), int'($urandom % 4), rd);
        end

        repeat (4) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

endmodule